// File: doc/BRIEF.md
# Overlay Plane Pixel Mixer

The mixer merges one pixel of the main picture plane (RGB555) with the co-located pixel of an overlay plane. The overlay pixel arrives as a 16-bit word in one of three encodings. The first is RGBA4444 with a 4-bit blend weight. The second is RGBA5551 with a 1-bit opaque/transparent flag. The third is RGB555, where transparency is marked by matching a programmed 15-bit key colour. The caller also supplies the current scan line number and an inclusive band of lines. The overlay is merged only when the mixer is enabled and the line falls inside that band. In every other case the main pixel is passed through untouched.

The datapath is a fixed two-stage pipeline. A valid flag rides alongside the data so that the output pixel and its qualifier leave together, two clock edges after they entered. All control inputs are sampled in the same cycle as the pixel they apply to.

Top module: `ovl_mixer`

## Requirements
- R1: When `ovl_en` is 0, `out_px` equals the `main_px` that entered with it, whatever the overlay inputs hold.
- R2: The overlay is applied only when `line_first <= line_num <= line_last` (both ends included); on any other line, including every line when `line_first > line_last`, `out_px` equals `main_px`.
- R3: With `ovl_fmt` = 2'b00 (RGBA4444: red [15:12], green [11:8], blue [7:4], weight a in [3:0]), each output channel is (m*(15-a) + o*a + 7) / 15 using integer division, where m is the main channel and o the widened overlay channel.
- R4: In RGBA4444 mode a 4-bit channel c is widened to 5 bits as {c, c[3]}, so that a = 15 outputs exactly the widened overlay colour and a = 0 outputs the main pixel.
- R5: With `ovl_fmt` = 2'b01 (RGBA5551: colour in [15:1], flag in [0]), a flag of 1 outputs `ovl_px[15:1]` and a flag of 0 outputs `main_px`.
- R6: With `ovl_fmt` = 2'b10 (key mode: colour in [14:0], bit 15 ignored), `ovl_px[14:0] == key_color` outputs `main_px`; any other value outputs `ovl_px[14:0]`.
- R7: The unused code `ovl_fmt` = 2'b11 outputs `main_px`.
- R8: Latency is exactly two clock cycles: `out_valid` and `out_px` in the cycle after the second rising edge reflect the `in_valid` and pixel inputs sampled at the first.
- R9: While `rst` is high, `out_valid` and `out_px` are 0.
- Pixel layout for `main_px`, `out_px` and `key_color`: red [14:10], green [9:5], blue [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| main_px | input | 15 | Main plane pixel, RGB555 |
| ovl_px | input | 16 | Overlay plane pixel, encoding set by `ovl_fmt` |
| line_num | input | LINE_W | Current scan line |
| ovl_en | input | 1 | Overlay merge enable |
| ovl_fmt | input | 2 | Overlay encoding: 00 RGBA4444, 01 RGBA5551, 10 key RGB555 |
| line_first | input | LINE_W | First line of the overlay band (inclusive) |
| line_last | input | LINE_W | Last line of the overlay band (inclusive) |
| key_color | input | 15 | Transparent colour for key mode |
| out_valid | output | 1 | Output qualifier, `in_valid` delayed by two cycles |
| out_px | output | 15 | Mixed RGB555 pixel |

## Verification
The weighted mode is swept over every weight against all 16 overlay nibbles and four main colours. The weight extremes separate the widening rule from the rounding in the blend, and the middle weights expose any error in the divide. Key mode is tried with an exact match, the match with bit 15 set, and each of the fifteen single-bit mismatches, which shows that every bit of the comparison counts. The line band is probed one line either side of each edge, with a one-line band and an inverted band. A stream of changing main pixels with an irregular valid pattern pins down the two-cycle alignment of data and qualifier.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int CH_W    = 5;
    localparam int NIB_W   = 4;
    localparam int PX_W    = 3 * CH_W;
    localparam int OVL_W   = 16;
    localparam int W_MAX   = (1 << NIB_W) - 1;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        FMT_W4   = 2'b00,
        FMT_W1   = 2'b01,
        FMT_KEY  = 2'b10,
        FMT_NONE = 2'b11
    } ovl_fmt_e;

    typedef enum logic [1:0] {
        PICK_MAIN = 2'd0,
        PICK_OVL  = 2'd1,
        PICK_MIX  = 2'd2
    } pick_e;

    typedef struct packed {
        pick_e            pick;
        logic [NIB_W-1:0] weight;
        rgb_t             px;
    } ovl_dec_t;

    function automatic logic [CH_W-1:0] widen_nib(input logic [NIB_W-1:0] c);
        return {c, c[NIB_W-1]};
    endfunction

    function automatic logic [CH_W-1:0] mix_chan(input logic [CH_W-1:0] m,
                                                 input logic [CH_W-1:0] o,
                                                 input logic [NIB_W-1:0] w);
        int acc;
        acc = int'(m) * (W_MAX - int'(w)) + int'(o) * int'(w) + (W_MAX / 2);
        return CH_W'(acc / W_MAX);
    endfunction

endpackage

// File: rtl/ovl_decode.sv
module ovl_decode
    import ovl_pkg::*;
(
    input  logic [OVL_W-1:0] ovl_px,
    input  logic [1:0]       fmt,
    input  logic [PX_W-1:0]  key_color,
    output ovl_dec_t         dec
);
    always_comb begin
        dec = '0;
        dec.pick = PICK_MAIN;
        case (ovl_fmt_e'(fmt))
            FMT_W4: begin
                dec.px.r   = widen_nib(ovl_px[15:12]);
                dec.px.g   = widen_nib(ovl_px[11:8]);
                dec.px.b   = widen_nib(ovl_px[7:4]);
                dec.weight = ovl_px[3:0];
                dec.pick   = PICK_MIX;
            end
            FMT_W1: begin
                dec.px   = rgb_t'(ovl_px[15:1]);
                dec.pick = ovl_px[0] ? PICK_OVL : PICK_MAIN;
            end
            FMT_KEY: begin
                dec.px   = rgb_t'(ovl_px[PX_W-1:0]);
                dec.pick = (ovl_px[PX_W-1:0] == key_color) ? PICK_MAIN : PICK_OVL;
            end
            default: dec.pick = PICK_MAIN;
        endcase
    end
endmodule

// File: rtl/ovl_window.sv
module ovl_window #(
    parameter int LINE_W = 11
) (
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] line_first,
    input  logic [LINE_W-1:0] line_last,
    output logic              in_band
);
    logic above_first;
    logic below_last;

    always_comb begin
        above_first = (line_num >= line_first);
        below_last  = (line_num <= line_last);
        in_band     = above_first && below_last;
    end
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
    import ovl_pkg::*;
(
    input  rgb_t     main_px,
    input  ovl_dec_t dec,
    output rgb_t     px
);
    localparam int N_CH = 3;

    logic [N_CH-1:0][CH_W-1:0] m_ch;
    logic [N_CH-1:0][CH_W-1:0] o_ch;
    logic [N_CH-1:0][CH_W-1:0] x_ch;

    assign m_ch = main_px;
    assign o_ch = dec.px;

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        assign x_ch[i] = mix_chan(m_ch[i], o_ch[i], dec.weight);
    end

    always_comb begin
        case (dec.pick)
            PICK_OVL: px = dec.px;
            PICK_MIX: px = rgb_t'(x_ch);
            default:  px = main_px;
        endcase
    end
endmodule

// File: rtl/ovl_mixer.sv
module ovl_mixer
    import ovl_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [14:0]       main_px,
    input  logic [15:0]       ovl_px,
    input  logic [LINE_W-1:0] line_num,
    input  logic              ovl_en,
    input  logic [1:0]        ovl_fmt,
    input  logic [LINE_W-1:0] line_first,
    input  logic [LINE_W-1:0] line_last,
    input  logic [14:0]       key_color,
    output logic              out_valid,
    output logic [14:0]       out_px
);
    ovl_dec_t dec_raw;
    ovl_dec_t dec_gated;
    logic     in_band;

    logic     s1_valid;
    rgb_t     s1_main;
    ovl_dec_t s1_dec;

    rgb_t     mixed;
    logic     s2_valid;
    rgb_t     s2_px;

    ovl_decode u_decode (
        .ovl_px    (ovl_px),
        .fmt       (ovl_fmt),
        .key_color (key_color),
        .dec       (dec_raw)
    );

    ovl_window #(.LINE_W(LINE_W)) u_window (
        .line_num   (line_num),
        .line_first (line_first),
        .line_last  (line_last),
        .in_band    (in_band)
    );

    always_comb begin
        dec_gated = dec_raw;
        if (!(ovl_en && in_band)) begin
            dec_gated.pick = PICK_MAIN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_main  <= '0;
            s1_dec   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_main  <= rgb_t'(main_px);
            s1_dec   <= dec_gated;
        end
    end

    ovl_blend u_blend (
        .main_px (s1_main),
        .dec     (s1_dec),
        .px      (mixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_px    <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_px    <= mixed;
        end
    end

    assign out_valid = s2_valid;
    assign out_px    = s2_px;
endmodule

// File: rtl/ovl_mixer_chk.sv
module ovl_mixer_chk #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [14:0]       main_px,
    input logic [15:0]       ovl_px,
    input logic [LINE_W-1:0] line_num,
    input logic              ovl_en,
    input logic [1:0]        ovl_fmt,
    input logic [LINE_W-1:0] line_first,
    input logic [LINE_W-1:0] line_last,
    input logic [14:0]       key_color,
    input logic              out_valid,
    input logic [14:0]       out_px
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)             age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(!ovl_en, 2)) |-> (out_px == $past(main_px, 2)));

    assert_outside_band_R2: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past((line_num < line_first) || (line_num > line_last), 2))
        |-> (out_px == $past(main_px, 2)));

    assert_key_match_R6: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(ovl_fmt == 2'b10 && ovl_px[14:0] == key_color, 2))
        |-> (out_px == $past(main_px, 2)));

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(ovl_en && ovl_fmt == 2'b01 && ovl_px[0] &&
                              line_num >= line_first && line_num <= line_last, 2))
        |-> (out_px == $past(ovl_px[15:1], 2)));

    assert_full_weight_R4: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(ovl_en && ovl_fmt == 2'b00 && ovl_px[3:0] == 4'hF &&
                              line_num >= line_first && line_num <= line_last, 2))
        |-> (out_px == $past({ovl_px[15:12], ovl_px[15], ovl_px[11:8], ovl_px[11],
                              ovl_px[7:4], ovl_px[7]}, 2)));

    assert_unused_code_R7: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(ovl_fmt == 2'b11, 2)) |-> (out_px == $past(main_px, 2)));
endmodule

bind ovl_mixer ovl_mixer_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .main_px    (main_px),
    .ovl_px     (ovl_px),
    .line_num   (line_num),
    .ovl_en     (ovl_en),
    .ovl_fmt    (ovl_fmt),
    .line_first (line_first),
    .line_last  (line_last),
    .key_color  (key_color),
    .out_valid  (out_valid),
    .out_px     (out_px)
);

// File: tb/tb_ovl_mixer.sv
`timescale 1ns/1ps
module tb_ovl_mixer;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [14:0]   main_px;
    logic [15:0]   ovl_px;
    logic [LW-1:0] line_num;
    logic          ovl_en;
    logic [1:0]    ovl_fmt;
    logic [LW-1:0] line_first;
    logic [LW-1:0] line_last;
    logic [14:0]   key_color;
    logic          out_valid;
    logic [14:0]   out_px;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ovl_mixer #(.LINE_W(LW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .main_px(main_px),
        .ovl_px(ovl_px), .line_num(line_num), .ovl_en(ovl_en), .ovl_fmt(ovl_fmt),
        .line_first(line_first), .line_last(line_last), .key_color(key_color),
        .out_valid(out_valid), .out_px(out_px)
    );

    function automatic int wid(input int c);
        return (c << 1) | (c >> 3);
    endfunction

    function automatic int bl(input int m, input int o, input int a);
        return (m * (15 - a) + o * a + 7) / 15;
    endfunction

    task automatic expect_eq(input string tag, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: out_px=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic run1(input string tag, input logic [14:0] mp, input logic [15:0] op,
                        input logic [LW-1:0] ln, input logic en, input logic [1:0] f,
                        input logic [14:0] exp);
        @(negedge clk);
        in_valid = 1'b1; main_px = mp; ovl_px = op; line_num = ln; ovl_en = en; ovl_fmt = f;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        expect_eq(tag, out_px, exp);
    endtask

    initial begin
        #(20.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [14:0] mp;
        logic [15:0] op;
        logic [14:0] ex;
        logic        pat [12];
        logic [14:0] mseq [12];

        rst = 1'b1; in_valid = 1'b1; main_px = 15'h7FFF; ovl_px = 16'hFFFF; line_num = '0;
        ovl_en = 1'b1; ovl_fmt = 2'b01; line_first = '0; line_last = 11'd2047;
        key_color = 15'h1234;
        repeat (3) @(negedge clk);
        // R9: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            errors++; $display("FAIL R9: out_valid=%b expected 0", out_valid);
        end
        expect_eq("R9", out_px, 15'h0);
        rst = 1'b0;

        // R3 / R4: weighted mode sweep
        for (int a = 0; a < 16; a++) begin
            for (int o = 0; o < 16; o++) begin
                for (int k = 0; k < 4; k++) begin
                    int mr, mg, mb, orr, og, ob;
                    mr = (k * 10 + 1) % 32; mg = 31 - mr; mb = mr ^ 21;
                    orr = o; og = 15 - o; ob = (o * 7) & 15;
                    mp = {5'(mr), 5'(mg), 5'(mb)};
                    op = {4'(orr), 4'(og), 4'(ob), 4'(a)};
                    ex = {5'(bl(mr, wid(orr), a)), 5'(bl(mg, wid(og), a)), 5'(bl(mb, wid(ob), a))};
                    run1((a == 15 || a == 0) ? "R4" : "R3", mp, op, 11'd5, 1'b1, 2'b00, ex);
                end
            end
        end

        // R5: single-bit flag mode
        for (int v = 0; v < 32; v++) begin
            mp = 15'(v * 977 + 3);
            op = {15'(v * 1231 + 77), v[0]};
            run1("R5", mp, op, 11'd9, 1'b1, 2'b01, v[0] ? op[15:1] : mp);
        end

        // R6: key mode, exact match, ignored top bit, single-bit mismatches
        mp = 15'h2A5A;
        run1("R6", mp, {1'b0, key_color}, 11'd1, 1'b1, 2'b10, mp);
        run1("R6", mp, {1'b1, key_color}, 11'd1, 1'b1, 2'b10, mp);
        for (int i = 0; i < 15; i++) begin
            op = {1'b1, key_color ^ (15'h1 << i)};
            run1("R6", mp, op, 11'd1, 1'b1, 2'b10, op[14:0]);
        end

        // R7: unused code
        run1("R7", 15'h1111, 16'hFFFF, 11'd3, 1'b1, 2'b11, 15'h1111);
        run1("R7", 15'h4321, 16'h0001, 11'd3, 1'b1, 2'b11, 15'h4321);

        // R1: disabled
        run1("R1", 15'h0F0F, 16'hABCD, 11'd3, 1'b0, 2'b01, 15'h0F0F);
        run1("R1", 15'h7000, 16'h000F, 11'd3, 1'b0, 2'b00, 15'h7000);
        run1("R1", 15'h0123, 16'h4567, 11'd3, 1'b0, 2'b10, 15'h0123);

        // R2: line band edges, one-line band, inverted band
        op = 16'h5555; mp = 15'h3333;
        line_first = 11'd10; line_last = 11'd20;
        for (int ln = 8; ln <= 22; ln++) begin
            run1("R2", mp, op, 11'(ln), 1'b1, 2'b01, (ln >= 10 && ln <= 20) ? op[15:1] : mp);
        end
        line_first = 11'd5; line_last = 11'd5;
        for (int ln = 4; ln <= 6; ln++) begin
            run1("R2", mp, op, 11'(ln), 1'b1, 2'b01, (ln == 5) ? op[15:1] : mp);
        end
        line_first = 11'd30; line_last = 11'd25;
        run1("R2", mp, op, 11'd27, 1'b1, 2'b01, mp);
        run1("R2", mp, op, 11'd30, 1'b1, 2'b01, mp);
        run1("R2", mp, op, 11'd25, 1'b1, 2'b01, mp);
        line_first = '0; line_last = 11'd2047;

        // R8: two-cycle alignment of data and qualifier
        pat = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
        ovl_en = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                checks++;
                if (out_valid !== pat[i-2]) begin
                    errors++;
                    $display("FAIL R8: out_valid=%b expected %b", out_valid, pat[i-2]);
                end
                expect_eq("R8", out_px, mseq[i-2]);
            end
            mseq[i]  = 15'(i * 2749 + 11);
            in_valid = pat[i];
            main_px  = mseq[i];
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule